// File: doc/BRIEF.md
# Main Control Decoder for a Single-Cycle Datapath

This block turns the 6-bit primary opcode and the 6-bit function code of a 32-bit instruction into every steering and enable signal a single-cycle datapath needs. It is purely combinational: the datapath presents the two fields during a cycle, and the controls are valid after the decode logic settles. The next state elements capture the resulting writes at the end of that cycle.

The decoder covers register-to-register ALU operations, word load and store, branch-on-equal, direct jump, jump-and-link, jump-register and jump-and-link-register. It also covers four immediate forms: add, AND, OR and unsigned set-less-than. To support linking and unsigned immediates, three selects each gain a third value. The destination select can name the fixed link register 31. The second ALU operand can be a zero-extended immediate. The write-back source can be the return address PC+4. Any opcode outside the supported set produces a safe state: no register or memory side effect, and sequential fetch.

Top module: `main_ctrl_decoder`

## Requirements
- R1: Opcode 0x00 with any function code other than 0x08 and 0x09 is an ALU register operation. It sets reg_write=1, reg_dst=1 (rd), alu_src=0 (rt), wb_src=0 (ALU), alu_op=2 (from function code) and pc_src=0 (sequential).
- R2: Opcode 0x23 (load) sets mem_read=1, reg_write=1, reg_dst=0 (rt), alu_src=1 (sign-extended), wb_src=1 (memory) and alu_op=0 (add). It leaves mem_write=0.
- R3: Opcode 0x2B (store) sets mem_write=1, alu_src=1 and alu_op=0. It leaves reg_write=0 and mem_read=0.
- R4: Opcode 0x04 (branch-equal) sets branch=1, pc_src=1 (branch target), alu_src=0 and alu_op=1 (subtract). It writes nothing.
- R5: Opcode 0x02 (jump) sets pc_src=2 (jump target) and writes nothing.
- R6: Opcode 0x03 (jump-and-link) sets pc_src=2, reg_write=1, reg_dst=2 (register 31) and wb_src=2 (PC+4).
- R7: Opcode 0x00 with function code 0x08 sets pc_src=3 (register target) and reg_write=0.
- R8: Opcode 0x00 with function code 0x09 sets pc_src=3, reg_write=1, reg_dst=2 and wb_src=2.
- R9: Opcode 0x08 (add immediate) sets reg_write=1, reg_dst=0, alu_src=1, wb_src=0 and alu_op=0.
- R10: Opcodes 0x0C and 0x0D set reg_write=1, reg_dst=0, alu_src=2 (zero-extended) and wb_src=0. They select alu_op=3 (AND) and alu_op=4 (OR) respectively.
- R11: Opcode 0x0B (unsigned set-less-than immediate) sets reg_write=1, reg_dst=0, alu_src=2, wb_src=0 and alu_op=5 (unsigned compare).
- R12: Any other opcode drives reg_write=0, mem_read=0, mem_write=0, branch=0 and pc_src=0, whatever the function code.
- R13: The function code has no effect on any output unless the opcode is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field |
| pc_src | output | 2 | Next-PC select: 0 PC+4, 1 branch target, 2 jump target, 3 register |
| branch | output | 1 | Conditional branch; gated with the ALU zero flag |
| reg_dst | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| alu_src | output | 2 | Second operand: 0 rt, 1 sign-extended, 2 zero-extended immediate |
| wb_src | output | 2 | Write value: 0 ALU, 1 memory, 2 PC+4 |
| alu_op | output | 3 | 0 add, 1 sub, 2 from function code, 3 AND, 4 OR, 5 unsigned less-than |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |

## Verification
Each supported opcode is applied with several function codes. This separates the two jump-register encodings from ordinary register operations, and shows that the function code is ignored for every non-zero opcode. A sweep over all 64 opcodes, including neighbours of valid codes such as 0x05 and 0x09, shows that only the listed codes can raise any write enable. Pairs that differ in a single field are compared against each other: immediate AND against OR, and link jump against plain jump. This confirms the third select values are used only where required.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JLINK   = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTIU   = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI    = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI     = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;
  localparam logic [FN_W-1:0]  FN_JREG     = 6'h08;
  localparam logic [FN_W-1:0]  FN_JRLINK   = 6'h09;

  typedef enum logic [1:0] {PCS_SEQ = 2'd0, PCS_BR = 2'd1, PCS_JMP = 2'd2, PCS_REG = 2'd3} pcs_e;
  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [1:0] {OPB_RT = 2'd0, OPB_SEXT = 2'd1, OPB_ZEXT = 2'd2} opb_e;
  typedef enum logic [1:0] {WS_ALU = 2'd0, WS_MEM = 2'd1, WS_RET = 2'd2} wsrc_e;
  typedef enum logic [2:0] {AO_ADD = 3'd0, AO_SUB = 3'd1, AO_FUNCT = 3'd2,
                            AO_AND = 3'd3, AO_OR = 3'd4, AO_SLTU = 3'd5} aluop_e;

  typedef enum logic [3:0] {
    K_ILLEGAL, K_ALU_R, K_JR, K_JALR, K_LW, K_SW, K_BEQ,
    K_J, K_JAL, K_ADDI, K_ANDI, K_ORI, K_SLTIU
  } kind_e;

  // Sort an instruction into one kind; the function code only matters for opcode 0.
  function automatic kind_e classify(input logic [OPC_W-1:0] opc, input logic [FN_W-1:0] fn);
    kind_e k;
    case (opc)
      OPC_SPECIAL: begin
        if (fn == FN_JREG)        k = K_JR;
        else if (fn == FN_JRLINK) k = K_JALR;
        else                      k = K_ALU_R;
      end
      OPC_LOAD:  k = K_LW;
      OPC_STORE: k = K_SW;
      OPC_BEQ:   k = K_BEQ;
      OPC_JUMP:  k = K_J;
      OPC_JLINK: k = K_JAL;
      OPC_ADDI:  k = K_ADDI;
      OPC_ANDI:  k = K_ANDI;
      OPC_ORI:   k = K_ORI;
      OPC_SLTIU: k = K_SLTIU;
      default:   k = K_ILLEGAL;
    endcase
    return k;
  endfunction

  // Kinds that save a return address in register 31.
  function automatic logic links(input kind_e k);
    return (k == K_JAL) || (k == K_JALR);
  endfunction

  // Kinds whose immediate is zero-extended.
  function automatic logic zext_imm(input kind_e k);
    return (k == K_ANDI) || (k == K_ORI) || (k == K_SLTIU);
  endfunction
endpackage

// File: rtl/mcd_classify.sv
module mcd_classify
  import mcd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  output kind_e            kind,
  output logic             illegal,
  output logic             link
);
  always_comb begin
    kind    = classify(opc, fn);
    illegal = (kind == K_ILLEGAL);
    link    = links(kind);
  end
endmodule

// File: rtl/mcd_flow.sv
module mcd_flow
  import mcd_pkg::*;
(
  input  kind_e kind,
  output pcs_e  pcs,
  output logic  br
);
  always_comb begin
    pcs = PCS_SEQ;
    br  = 1'b0;
    case (kind)
      K_BEQ:        begin pcs = PCS_BR; br = 1'b1; end
      K_J, K_JAL:   pcs = PCS_JMP;
      K_JR, K_JALR: pcs = PCS_REG;
      default:      pcs = PCS_SEQ;
    endcase
  end
endmodule

// File: rtl/mcd_dpath.sv
module mcd_dpath
  import mcd_pkg::*;
(
  input  kind_e  kind,
  input  logic   link,
  output dst_e   dst,
  output opb_e   opb,
  output wsrc_e  ws,
  output aluop_e aop,
  output logic   rw,
  output logic   mrd,
  output logic   mwr
);
  always_comb begin
    dst = DST_RT;
    ws  = WS_ALU;
    aop = AO_ADD;
    rw  = 1'b0;
    mrd = 1'b0;
    mwr = 1'b0;
    if (zext_imm(kind))
      opb = OPB_ZEXT;
    else if (kind == K_LW || kind == K_SW || kind == K_ADDI)
      opb = OPB_SEXT;
    else
      opb = OPB_RT;
    if (link) begin
      dst = DST_LINK;
      ws  = WS_RET;
      rw  = 1'b1;
    end
    case (kind)
      K_ALU_R, K_JR, K_JALR: begin
        aop = AO_FUNCT;
        if (kind == K_ALU_R) begin dst = DST_RD; rw = 1'b1; end
      end
      K_LW:    begin mrd = 1'b1; rw = 1'b1; ws = WS_MEM; end
      K_SW:    mwr = 1'b1;
      K_BEQ:   aop = AO_SUB;
      K_ADDI:  rw = 1'b1;
      K_ANDI:  begin aop = AO_AND;  rw = 1'b1; end
      K_ORI:   begin aop = AO_OR;   rw = 1'b1; end
      K_SLTIU: begin aop = AO_SLTU; rw = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
  import mcd_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic [1:0] pc_src,
  output logic       branch,
  output logic [1:0] reg_dst,
  output logic [1:0] alu_src,
  output logic [1:0] wb_src,
  output logic [2:0] alu_op,
  output logic       reg_write,
  output logic       mem_read,
  output logic       mem_write
);
  kind_e  kind;
  logic   is_illegal;
  logic   is_link;
  pcs_e   pcs;
  dst_e   dst;
  opb_e   opb;
  wsrc_e  ws;
  aluop_e aop;

  mcd_classify u_cls (.opc(opcode), .fn(funct), .kind(kind), .illegal(is_illegal), .link(is_link));
  mcd_flow     u_flow (.kind(kind), .pcs(pcs), .br(branch));
  mcd_dpath    u_dp (.kind(kind), .link(is_link), .dst(dst), .opb(opb), .ws(ws), .aop(aop),
                     .rw(reg_write), .mrd(mem_read), .mwr(mem_write));

  assign pc_src  = pcs;
  assign reg_dst = dst;
  assign alu_src = opb;
  assign wb_src  = ws;
  assign alu_op  = aop;
endmodule

// File: rtl/mcd_chk.sv
module mcd_chk (
  input logic [5:0] opcode,
  input logic [1:0] pc_src,
  input logic       branch,
  input logic [1:0] reg_dst,
  input logic [1:0] alu_src,
  input logic [1:0] wb_src,
  input logic [2:0] alu_op,
  input logic       reg_write,
  input logic       mem_read,
  input logic       mem_write,
  input logic       is_illegal,
  input logic       is_link
);
  always_comb begin
    // R3
    store_no_regwr_chk: assert (!(mem_write && (reg_write || mem_read)));
    // R2
    load_wb_mem_chk: assert (!mem_read || (wb_src == 2'd1 && reg_write));
    // R6
    link_dst_chk: assert (is_link == (reg_dst == 2'd2)) ;
    // R8
    link_ret_chk: assert (!is_link || (wb_src == 2'd2 && reg_write));
    // R4
    branch_sub_chk: assert (!branch || (pc_src == 2'd1 && alu_op == 3'd1 && !reg_write));
    // R12
    illegal_safe_chk: assert (!is_illegal || (!reg_write && !mem_read && !mem_write && pc_src == 2'd0));
    // R10
    zext_only_chk: assert (alu_src != 2'd2 || opcode inside {6'h0B, 6'h0C, 6'h0D});
  end
endmodule

bind main_ctrl_decoder mcd_chk chk_i (
  .opcode(opcode), .pc_src(pc_src), .branch(branch), .reg_dst(reg_dst),
  .alu_src(alu_src), .wb_src(wb_src), .alu_op(alu_op), .reg_write(reg_write),
  .mem_read(mem_read), .mem_write(mem_write), .is_illegal(is_illegal), .is_link(is_link)
);

// File: tb/main_ctrl_decoder_tb_top.sv
module main_ctrl_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] opcode, funct;
  logic [1:0] pc_src, reg_dst, alu_src, wb_src;
  logic [2:0] alu_op;
  logic branch, reg_write, mem_read, mem_write;

  main_ctrl_decoder dut_i (
    .opcode(opcode), .funct(funct), .pc_src(pc_src), .branch(branch),
    .reg_dst(reg_dst), .alu_src(alu_src), .wb_src(wb_src), .alu_op(alu_op),
    .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write)
  );

  // Packed expectation: pc2 br1 dst2 src2 wb2 op3 rw1 mr1 mw1
  typedef struct {
    logic [14:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  function automatic logic [14:0] pack(input logic [1:0] pc, input logic br, input logic [1:0] d,
                                       input logic [1:0] s, input logic [1:0] w, input logic [2:0] o,
                                       input logic rw, input logic mr, input logic mw);
    return {pc, br, d, s, w, o, rw, mr, mw};
  endfunction

  // Reference model written from the requirement list.
  function automatic logic [14:0] model(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'h00: begin
        if (fn == 6'h08)      return pack(2'd3, 0, 2'd0, 2'd0, 2'd0, 3'd2, 0, 0, 0); // R7
        else if (fn == 6'h09) return pack(2'd3, 0, 2'd2, 2'd0, 2'd2, 3'd2, 1, 0, 0); // R8
        else                  return pack(2'd0, 0, 2'd1, 2'd0, 2'd0, 3'd2, 1, 0, 0); // R1
      end
      6'h23: return pack(2'd0, 0, 2'd0, 2'd1, 2'd1, 3'd0, 1, 1, 0); // R2
      6'h2B: return pack(2'd0, 0, 2'd0, 2'd1, 2'd0, 3'd0, 0, 0, 1); // R3
      6'h04: return pack(2'd1, 1, 2'd0, 2'd0, 2'd0, 3'd1, 0, 0, 0); // R4
      6'h02: return pack(2'd2, 0, 2'd0, 2'd0, 2'd0, 3'd0, 0, 0, 0); // R5
      6'h03: return pack(2'd2, 0, 2'd2, 2'd0, 2'd2, 3'd0, 1, 0, 0); // R6
      6'h08: return pack(2'd0, 0, 2'd0, 2'd1, 2'd0, 3'd0, 1, 0, 0); // R9
      6'h0C: return pack(2'd0, 0, 2'd0, 2'd2, 2'd0, 3'd3, 1, 0, 0); // R10
      6'h0D: return pack(2'd0, 0, 2'd0, 2'd2, 2'd0, 3'd4, 1, 0, 0); // R10
      6'h0B: return pack(2'd0, 0, 2'd0, 2'd2, 2'd0, 3'd5, 1, 0, 0); // R11
      default: return pack(2'd0, 0, 2'd0, 2'd0, 2'd0, 3'd0, 0, 0, 0); // R12
    endcase
  endfunction

  function automatic logic [14:0] observed();
    return {pc_src, branch, reg_dst, alu_src, wb_src, alu_op, reg_write, mem_read, mem_write};
  endfunction

  task automatic drive(input logic [5:0] op, input logic [5:0] fn, input string tag);
    item_t it;
    @(negedge clk);
    opcode = op;
    funct  = fn;
    it.exp = model(op, fn);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares one item per rising edge, half a period after the drive.
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (observed() !== it.exp) begin
          errors++;
          $display("FAIL %s op=%02h fn=%02h actual=%b expected=%b", it.tag, opcode, funct, observed(), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    opcode = 6'h3F;
    funct  = 6'h00;
    repeat (3) @(posedge clk);
    // Safe state while held in reset with an undefined opcode.
    drive(6'h3F, 6'h00, "R12 reset");
    rst_n = 1'b1;

    drive(6'h00, 6'h20, "R1 add");
    drive(6'h00, 6'h22, "R1 sub");
    drive(6'h00, 6'h24, "R1 and");
    drive(6'h00, 6'h0A, "R1 near-jalr");
    drive(6'h23, 6'h00, "R2 load");
    drive(6'h2B, 6'h3F, "R3 store");
    drive(6'h04, 6'h08, "R4 beq");
    drive(6'h02, 6'h09, "R5 j");
    drive(6'h03, 6'h00, "R6 jal");
    drive(6'h00, 6'h08, "R7 jr");
    drive(6'h00, 6'h09, "R8 jalr");
    drive(6'h08, 6'h11, "R9 addi");
    drive(6'h0C, 6'h00, "R10 andi");
    drive(6'h0D, 6'h00, "R10 ori");
    drive(6'h0B, 6'h2A, "R11 sltiu");
    drive(6'h05, 6'h00, "R12 bne-like");
    drive(6'h09, 6'h09, "R12 near-addi");

    // R13: function code ignored for nonzero opcodes, including jr/jalr codes.
    for (int op = 1; op < 64; op++) begin
      drive(op[5:0], 6'h08, "R13 fn08");
      drive(op[5:0], 6'h09, "R13 fn09");
      drive(op[5:0], 6'h2B, "R13 fn2B");
    end
    // R12 sweep over all opcodes.
    for (int op = 0; op < 64; op++) drive(op[5:0], 6'h00, "R12 sweep");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule